// File: doc/BRIEF.md
# Zero-Register Register Bank

This block is the architectural register bank of a small 32-bit load/store processor. It holds 32 words of 32 bits. Two read ports serve the two source operands of an instruction. A single write port takes the result being retired. Both read ports are purely combinational: the data follows the address within the same cycle, and nothing is registered on the read side. The write port commits on the rising clock edge.

The highest-numbered entry is the constant-zero register. Software uses it as a source of zero and as a sink for results it does not need. Every read of that index returns zero, and every write to it is dropped. Only the lower 31 entries therefore hold storage. A synchronous, active-high reset clears them. Reset takes priority over a write presented in the same cycle.

There is no bypass from the write port to the read ports. A read of the entry being written in the same cycle still sees the stored value. The new value appears on the cycle after the edge.

Top module: `zreg_bank`

## Requirements
- R1: The bank holds 32 entries of 32 bits, selected by a 5-bit address. Each of entries 0 to 30 returns, on either read port, the last value written to it.
- R2: A write commits on the rising clock edge when `wr_en` is 1, `rst` is 0 and `wr_addr` is not 31. The value is visible on the read ports from the cycle after that edge.
- R3: A read port whose address is 31 outputs 32'h0000_0000, whatever data has been presented for entry 31.
- R4: When `wr_en` is 0, a clock edge leaves every entry unchanged.
- R5: A write with `wr_addr` equal to 31 changes no entry, even with `wr_en` at 1.
- R6: While `rst` is 1 at a rising edge, entries 0 to 30 become zero after that edge, and a write presented in the same cycle is discarded.
- R7: A read of the address being written in the same cycle returns the old contents of that entry, not the write data.
- R8: The two read ports are independent. Each outputs the contents of its own address in the same cycle, including when both ports select the same entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of entries 0 to 30 |
| rd_addr_a | input | 5 | Read port A address |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_a | output | 32 | Read port A data, combinational from `rd_addr_a` |
| rd_data_b | output | 32 | Read port B data, combinational from `rd_addr_b` |
| wr_addr | input | 5 | Write port address |
| wr_data | input | 32 | Write port data |
| wr_en | input | 1 | Write enable |

## Verification
A read and a write can target the same entry in one cycle. Likewise, reset and a write can arrive on the same edge. The stimulus provokes the first case with directed cycles in which a read address equals the write address, and also with random traffic over a narrow address range where such matches are frequent. Outputs are sampled before the edge and judged against a reference array that still holds the old value (R7). For the reset collision, a write is raised together with reset, and the written entry is then read back expecting zero (R6).

// File: rtl/zrb_pkg.sv
package zrb_pkg;
    parameter int ZRB_DATA_W   = 32;
    parameter int ZRB_NUM_REGS = 32;
endpackage

// File: rtl/zrb_store.sv
module zrb_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int ZERO_IDX = NUM_REGS - 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    bank_q
);
    // Storage exists only for the entries below the zero index.
    for (genvar i = 0; i < ZERO_IDX; i++) begin : g_entry
        logic [DATA_W-1:0] word_q;
        logic              hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (hit) begin
                word_q <= wr_data;
            end
        end

        assign bank_q[i] = word_q;
    end

    // The zero entry has no flop behind it.
    assign bank_q[ZERO_IDX] = '0;
endmodule

// File: rtl/zrb_rdport.sv
module zrb_rdport #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int ZERO_IDX = NUM_REGS - 1
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data
);
    always_comb begin
        if (rd_addr == ADDR_W'(ZERO_IDX)) begin
            rd_data = '0;
        end else begin
            rd_data = bank_q[rd_addr];
        end
    end
endmodule

// File: rtl/zreg_bank.sv
module zreg_bank
    import zrb_pkg::*;
#(
    parameter int DATA_W   = ZRB_DATA_W,
    parameter int NUM_REGS = ZRB_NUM_REGS,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int N_RD    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en
);
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
    logic [N_RD-1:0][ADDR_W-1:0]     rd_addr_v;
    logic [N_RD-1:0][DATA_W-1:0]     rd_data_v;

    zrb_store #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        zrb_rdport #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS)
        ) u_port (
            .bank_q  (bank_q),
            .rd_addr (rd_addr_v[p]),
            .rd_data (rd_data_v[p])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];
endmodule

// File: rtl/zrb_checker.sv
module zrb_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en
);
    localparam logic [ADDR_W-1:0] TOP_A = '1;

    // R3: the zero entry reads as zero on both ports
    p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == TOP_A) |-> (rd_data_a == '0));
    p_zero_read_b_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == TOP_A) |-> (rd_data_b == '0));

    // R2: a committed write is visible on the next cycle
    p_write_seen_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != TOP_A) |=> (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

    // R4: without a write, a held address keeps its data
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> (rd_addr_a != $past(rd_addr_a) || $past(rst) || rd_data_a == $past(rd_data_a)));

    // R5: a write aimed at the zero entry disturbs nothing
    p_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == TOP_A) |=> (rd_addr_b != $past(rd_addr_b) || $past(rst) || rd_data_b == $past(rd_data_b)));

    // R6: the cycle after reset every read is zero
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0));
endmodule

bind zreg_bank zrb_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en)
);

// File: tb/zreg_bank_tb.sv
module zreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] ref_q [32];

    always #2 clk = ~clk;

    zreg_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en)
    );

    function automatic logic [31:0] expect_rd(input logic [4:0] a);
        return (a == 5'd31) ? 32'h0 : ref_q[a];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle on the falling edge, check reads before the rising edge,
    // then advance the reference model past the edge.
    task automatic cycle(input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] wa,
                         input logic [31:0] wd, input logic we, input logic r, input string req);
        @(negedge clk);
        rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd; wr_en = we; rst = r;
        #1;
        check(req, rd_data_a, expect_rd(ra));
        check(req, rd_data_b, expect_rd(rb));
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 32; i++) ref_q[i] = 32'h0;
        end else if (we && wa != 5'd31) begin
            ref_q[wa] = wd;
        end
    endtask

    function automatic string tag_for(input logic [4:0] ra, input logic [4:0] wa, input logic we);
        if (ra == 5'd31) return "R3";
        if (we && ra == wa) return "R7";
        return "R8";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) ref_q[i] = 32'h0;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
        repeat (2) @(posedge clk);
        // R6: reset state, every address on both ports
        for (int i = 0; i < 32; i++) cycle(5'(i), 5'(31 - i), 5'd0, 32'h0, 1'b0, 1'b0, "R6");

        // R1 / R2: fill every address, then read each back on both ports
        for (int i = 0; i < 32; i++) cycle(5'd0, 5'd1, 5'(i), 32'hA500_0000 | 32'(i * 32'h01010101), 1'b1, 1'b0, "R1");
        for (int i = 0; i < 32; i++) cycle(5'(i), 5'(i), 5'd0, 32'h0, 1'b0, 1'b0, "R1");
        // R2: written value appears on the following cycle
        cycle(5'd4, 5'd4, 5'd4, 32'hCAFE_0004, 1'b1, 1'b0, "R7");
        cycle(5'd4, 5'd5, 5'd0, 32'h0, 1'b0, 1'b0, "R2");
        // R3 / R5: write to entry 31 then read it and its neighbour
        cycle(5'd31, 5'd30, 5'd31, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");
        cycle(5'd31, 5'd30, 5'd0, 32'h0, 1'b0, 1'b0, "R3");
        // R4: data presented with enable low is ignored
        cycle(5'd7, 5'd8, 5'd7, 32'hDEAD_BEEF, 1'b0, 1'b0, "R4");
        cycle(5'd7, 5'd8, 5'd0, 32'h0, 1'b0, 1'b0, "R4");
        // R7: same-cycle read of the written address sees old data
        cycle(5'd9, 5'd9, 5'd9, 32'h1234_5678, 1'b1, 1'b0, "R7");
        cycle(5'd9, 5'd3, 5'd0, 32'h0, 1'b0, 1'b0, "R2");
        // R6: reset wins over a simultaneous write
        cycle(5'd12, 5'd13, 5'd12, 32'h5555_AAAA, 1'b1, 1'b1, "R6");
        cycle(5'd12, 5'd13, 5'd0, 32'h0, 1'b0, 1'b0, "R6");
        cycle(5'd0, 5'd30, 5'd0, 32'h0, 1'b0, 1'b0, "R6");

        // Random traffic: full range, then a narrow range for frequent collisions (R7, R8)
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ra, rb, wa;
            logic       we;
            if (n < 1500) begin
                ra = 5'($urandom); rb = 5'($urandom); wa = 5'($urandom);
            end else begin
                ra = 5'(28 + $urandom_range(0, 3)); rb = 5'(28 + $urandom_range(0, 3));
                wa = 5'(28 + $urandom_range(0, 3));
            end
            we = ($urandom_range(0, 3) != 0);
            cycle(ra, rb, wa, $urandom, we, ($urandom_range(0, 199) == 0), tag_for(ra, wa, we));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule